// File: doc/BRIEF.md
# Segmented Sequence Acquisition Manager

This block runs multi-trigger capture. The acquisition memory is split into equal segments, and each segment holds one triggered record. A start command loads the segment count and the segment length, then arms the capture controller for segment 0. Each trigger accepted while armed records the value of a free-running sample-clock counter. That value goes out on a write port addressed by the segment index, so an external timestamp RAM holds one entry per trigger. The time between any two triggers in the sequence is the difference of their entries.

When the capture controller reports that a segment is complete, the manager moves the base address forward by one segment length and re-arms after a fixed short delay. The new base is formed by addition, never by multiplication. After the last segment the manager stops arming and holds a done flag until the next start. A segment count of 0 or 1 selects single-record mode. In that mode the whole memory is one linear buffer starting at address 0.

Top module: `seq_acq_mgr`

## Requirements
- R1: During and after reset, until the first start, `arm_req`, `all_done` and `ts_we` are 0 and `base_addr` is 0.
- R2: A start in cycle c latches `seg_count` and `seg_len`. From cycle c+1, `arm_req` is 1, `base_addr` is 0 and the next timestamp goes to index 0. A start also restarts a sequence that is already running.
- R3: While armed for segment k, `base_addr` equals k × `seg_len` × 2^UNIT_LOG2, taken modulo 2^ADDR_W. `seg_len` counts allocation units of 2^UNIT_LOG2 samples, which is 8192 by default.
- R4: A latched count of 0 or 1 gives single-record mode. `base_addr` stays 0 whatever `seg_len` is, and completion of the one record ends the sequence. Counts from 2 up to 2^CNT_W−1 give sequence mode, with 8000 supported by default.
- R5: A trigger in cycle t while `arm_req` is 1 drops `arm_req` from cycle t+1. In cycle t+1 it also produces exactly one `ts_we` pulse, with `ts_addr` equal to the current segment index and `ts_data` equal to the value `ts_count` had in cycle t.
- R6: A trigger while `arm_req` is 0 is ignored: there is no `ts_we` pulse and no change in state.
- R7: `cap_done` acts only between an accepted trigger and segment completion. At any other time it is ignored, and `arm_req`, `base_addr` and `all_done` stay unchanged.
- R8: `cap_done` in cycle c for a segment that is not the last gives `arm_req` = 0 in cycle c+1 and `arm_req` = 1 in cycle c+2, with the base advanced by one segment.
- R9: `cap_done` for the last segment raises `all_done` from the next cycle. `all_done` stays 1 and `arm_req` stays 0 until a start arrives, and triggers and `cap_done` have no effect in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; latches configuration and arms segment 0 |
| seg_count | input | CNT_W | Number of segments (0 or 1 selects single-record mode) |
| seg_len | input | LEN_W | Segment length in allocation units |
| trig | input | 1 | Trigger pulse |
| cap_done | input | 1 | Capture controller reports the current segment complete |
| ts_count | input | TS_W | Free-running sample-clock counter |
| base_addr | output | ADDR_W | Base address of the segment being armed or filled |
| arm_req | output | 1 | Request to the capture controller to wait for a trigger |
| ts_we | output | 1 | Timestamp write strobe |
| ts_addr | output | CNT_W | Timestamp write index (segment index) |
| ts_data | output | TS_W | Latched counter value |
| all_done | output | 1 | All segments captured |

## Verification
Each result has a fixed delay after its stimulus, and the bench samples at exactly that delay:

| Stimulus in cycle c | Result | Due in cycle |
|---|---|---|
| start | `arm_req` and the zero base | c+1 |
| accepted trigger | timestamp write and the fall of `arm_req` | c+1 |
| `cap_done` (not last segment) | `arm_req` low | c+1 |
| `cap_done` (not last segment) | `arm_req` high again, new base | c+2 |
| `cap_done` (last segment) | `all_done` | c+1 |

Inputs change on the falling edge, and every output is checked on a later falling edge counted from the rising edge that samples the stimulus. The bench counts its own `ts_count` and records the value it presents at the trigger edge. It forms each base from the product of index, length and unit size. Ignored triggers and `cap_done` pulses are each followed by a check one falling edge later on the outputs they could have changed.

// File: rtl/seqacq_pkg.sv
package seqacq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_CAPT  = 3'd2,
      ST_STEP  = 3'd3,
      ST_DONE  = 3'd4
   } seq_state_t;

endpackage

// File: rtl/seq_seg_addr.sv
module seq_seg_addr #(
   parameter int ADDR_W    = 24,
   parameter int UNIT_LOG2 = 13,
   parameter int LEN_W     = 11,
   parameter int CNT_W     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [CNT_W-1:0]  seg_count,
   input  logic [LEN_W-1:0]  seg_len,
   output logic [ADDR_W-1:0] base,
   output logic [CNT_W-1:0]  idx,
   output logic              last_seg
);
   localparam int SPAN_W = LEN_W + UNIT_LOG2;

   logic [SPAN_W-1:0] span;
   logic [ADDR_W-1:0] stride_in;
   logic [ADDR_W-1:0] stride_q;
   logic [CNT_W-1:0]  total_q;
   logic              single_in;

   assign span      = SPAN_W'(seg_len) << UNIT_LOG2;
   assign single_in = (seg_count <= CNT_W'(1));

   // fit the segment span into the address width
   generate
      if (SPAN_W >= ADDR_W) begin : g_trunc
         assign stride_in = span[ADDR_W-1:0];
      end else begin : g_extend
         assign stride_in = ADDR_W'(span);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stride_q <= '0;
         total_q  <= CNT_W'(1);
         base     <= '0;
         idx      <= '0;
      end else if (load) begin
         stride_q <= single_in ? '0 : stride_in;
         total_q  <= single_in ? CNT_W'(1) : seg_count;
         base     <= '0;
         idx      <= '0;
      end else if (advance) begin
         base <= base + stride_q;
         idx  <= idx + CNT_W'(1);
      end
   end

   assign last_seg = (idx == total_q - CNT_W'(1));
endmodule

// File: rtl/seq_ts_port.sv
module seq_ts_port #(
   parameter int TS_W  = 48,
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [CNT_W-1:0] idx,
   input  logic [TS_W-1:0]  ts_count,
   output logic             we,
   output logic [CNT_W-1:0] addr,
   output logic [TS_W-1:0]  data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we   <= 1'b0;
         addr <= '0;
         data <= '0;
      end else begin
         we <= take;
         if (take) begin
            addr <= idx;
            data <= ts_count;
         end
      end
   end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import seqacq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       trig,
   input  logic       cap_done,
   input  logic       last_seg,
   output logic       load,
   output logic       advance,
   output logic       take_ts,
   output logic       armed,
   output logic       done
);
   seq_state_t st_q, st_d;

   always_comb begin
      st_d    = st_q;
      load    = 1'b0;
      advance = 1'b0;
      take_ts = 1'b0;
      if (start) begin
         load = 1'b1;
         st_d = ST_ARMED;
      end else begin
         unique case (st_q)
            ST_ARMED: if (trig) begin
               take_ts = 1'b1;
               st_d    = ST_CAPT;
            end
            ST_CAPT: if (cap_done) begin
               if (last_seg) begin
                  st_d = ST_DONE;
               end else begin
                  advance = 1'b1;
                  st_d    = ST_STEP;
               end
            end
            ST_STEP: st_d = ST_ARMED;
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign armed = (st_q == ST_ARMED);
   assign done  = (st_q == ST_DONE);
endmodule

// File: rtl/seq_acq_mgr.sv
module seq_acq_mgr #(
   parameter int ADDR_W    = 24,
   parameter int UNIT_LOG2 = 13,
   parameter int LEN_W     = 11,
   parameter int CNT_W     = 13,
   parameter int TS_W      = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  seg_count,
   input  logic [LEN_W-1:0]  seg_len,
   input  logic              trig,
   input  logic              cap_done,
   input  logic [TS_W-1:0]   ts_count,
   output logic [ADDR_W-1:0] base_addr,
   output logic              arm_req,
   output logic              ts_we,
   output logic [CNT_W-1:0]  ts_addr,
   output logic [TS_W-1:0]   ts_data,
   output logic              all_done
);
   // elaboration-time parameter checks
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must allow at least two segments");
      end
      if (UNIT_LOG2 >= ADDR_W) begin : g_bad_unit
         $error("allocation unit must be smaller than the address space");
      end
      if (TS_W < 1 || LEN_W < 1) begin : g_bad_w
         $error("TS_W and LEN_W must be positive");
      end
   endgenerate

   logic load, advance, take_ts, last_seg;
   logic [CNT_W-1:0] seg_idx;

   seq_ctrl i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .trig     (trig),
      .cap_done (cap_done),
      .last_seg (last_seg),
      .load     (load),
      .advance  (advance),
      .take_ts  (take_ts),
      .armed    (arm_req),
      .done     (all_done)
   );

   seq_seg_addr #(
      .ADDR_W    (ADDR_W),
      .UNIT_LOG2 (UNIT_LOG2),
      .LEN_W     (LEN_W),
      .CNT_W     (CNT_W)
   ) i_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .advance   (advance),
      .seg_count (seg_count),
      .seg_len   (seg_len),
      .base      (base_addr),
      .idx       (seg_idx),
      .last_seg  (last_seg)
   );

   seq_ts_port #(
      .TS_W  (TS_W),
      .CNT_W (CNT_W)
   ) i_ts (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take_ts),
      .idx      (seg_idx),
      .ts_count (ts_count),
      .we       (ts_we),
      .addr     (ts_addr),
      .data     (ts_data)
   );
endmodule

// File: rtl/seq_acq_chk.sv
module seq_acq_chk #(
   parameter int ADDR_W    = 24,
   parameter int UNIT_LOG2 = 13,
   parameter int LEN_W     = 11,
   parameter int CNT_W     = 13,
   parameter int TS_W      = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  seg_count,
   input logic [LEN_W-1:0]  seg_len,
   input logic              trig,
   input logic              cap_done,
   input logic [ADDR_W-1:0] base_addr,
   input logic              arm_req,
   input logic              ts_we,
   input logic              all_done
);
   // independent model of the per-segment stride, latched on start
   logic [ADDR_W-1:0] m_stride;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_stride <= '0;
      else if (start)
         m_stride <= (seg_count <= CNT_W'(1)) ? '0
                     : ADDR_W'((ADDR_W+LEN_W)'(seg_len) << UNIT_LOG2);
   end

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!arm_req && !all_done && !ts_we));

   assert_start_base_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (arm_req && base_addr == '0));

   assert_base_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(arm_req) && !$past(start)) |-> (base_addr == $past(base_addr, 2) + m_stride));

   assert_ts_only_when_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ts_we |-> ($past(trig) && $past(arm_req) && !$past(start)));

   assert_ts_drops_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ts_we |-> !arm_req);

   assert_rearm_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm_req) |-> ($past(start) || $past(cap_done, 2)));

   assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (all_done && !start) |=> (all_done && !arm_req));

   assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({all_done, arm_req}));
endmodule

bind seq_acq_mgr seq_acq_chk #(
   .ADDR_W    (ADDR_W),
   .UNIT_LOG2 (UNIT_LOG2),
   .LEN_W     (LEN_W),
   .CNT_W     (CNT_W),
   .TS_W      (TS_W)
) i_seq_acq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .seg_count (seg_count),
   .seg_len   (seg_len),
   .trig      (trig),
   .cap_done  (cap_done),
   .base_addr (base_addr),
   .arm_req   (arm_req),
   .ts_we     (ts_we),
   .all_done  (all_done)
);

// File: tb/test_seq_acq_mgr.sv
`timescale 1ns/1ps
module test_seq_acq_mgr;
   localparam int ADDR_W    = 10;
   localparam int UNIT_LOG2 = 2;
   localparam int LEN_W     = 4;
   localparam int CNT_W     = 4;
   localparam int TS_W      = 48;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  seg_count = '0;
   logic [LEN_W-1:0]  seg_len = '0;
   logic              trig = 1'b0;
   logic              cap_done = 1'b0;
   logic [TS_W-1:0]   ts_count = 48'hFFFF_FFFF_FFC0;
   logic [ADDR_W-1:0] base_addr;
   logic              arm_req;
   logic              ts_we;
   logic [CNT_W-1:0]  ts_addr;
   logic [TS_W-1:0]   ts_data;
   logic              all_done;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) ts_count <= ts_count + 48'd1;

   seq_acq_mgr #(
      .ADDR_W(ADDR_W), .UNIT_LOG2(UNIT_LOG2), .LEN_W(LEN_W),
      .CNT_W(CNT_W), .TS_W(TS_W)
   ) i_seq_acq_mgr (
      .clk(clk), .rst_n(rst_n), .start(start), .seg_count(seg_count),
      .seg_len(seg_len), .trig(trig), .cap_done(cap_done), .ts_count(ts_count),
      .base_addr(base_addr), .arm_req(arm_req), .ts_we(ts_we), .ts_addr(ts_addr),
      .ts_data(ts_data), .all_done(all_done)
   );

   task automatic chk(input bit ok, input string rid, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rid, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_start(input int cnt, input int len);
      seg_count = CNT_W'(cnt);
      seg_len   = LEN_W'(len);
      start     = 1'b1;
      step();
      start = 1'b0;
      chk(arm_req == 1'b1, "R2", "arm after start", 64'(arm_req), 64'd1);
      chk(base_addr == '0, "R2", "base after start", 64'(base_addr), 64'd0);
      chk(all_done == 1'b0, "R2", "done cleared", 64'(all_done), 64'd0);
   endtask

   // run one full sequence with checks on every segment
   task automatic run_seq(input int cnt, input int len, input bit probe);
      int eff;
      logic [TS_W-1:0] exp_ts;
      logic [ADDR_W-1:0] exp_base;
      eff = (cnt <= 1) ? 1 : cnt;
      do_start(cnt, len);
      for (int k = 0; k < eff; k++) begin
         exp_base = (cnt <= 1) ? '0 : ADDR_W'(k * len * (1 << UNIT_LOG2));
         chk(base_addr == exp_base, (cnt <= 1) ? "R4" : "R3", "segment base",
             64'(base_addr), 64'(exp_base));
         if (probe && k == 0) begin
            cap_done = 1'b1;
            step();
            cap_done = 1'b0;
            chk(arm_req == 1'b1 && base_addr == exp_base, "R7", "cap_done while armed",
                64'({arm_req, base_addr}), 64'({1'b1, exp_base}));
         end
         exp_ts = ts_count;
         trig = 1'b1;
         step();
         trig = 1'b0;
         chk(ts_we == 1'b1, "R5", "ts write strobe", 64'(ts_we), 64'd1);
         chk(ts_addr == CNT_W'(k), "R5", "ts index", 64'(ts_addr), 64'(k));
         chk(ts_data == exp_ts, "R5", "ts value", 64'(ts_data), 64'(exp_ts));
         chk(arm_req == 1'b0, "R5", "arm dropped", 64'(arm_req), 64'd0);
         if (probe) begin
            trig = 1'b1;
            step();
            trig = 1'b0;
            chk(ts_we == 1'b0, "R6", "trigger while capturing", 64'(ts_we), 64'd0);
         end
         repeat ((k % 3) + 1) step();
         cap_done = 1'b1;
         step();
         cap_done = 1'b0;
         if (k == eff - 1) begin
            chk(all_done == 1'b1 && arm_req == 1'b0, (cnt <= 1) ? "R4" : "R9",
                "done after last", 64'({all_done, arm_req}), 64'h2);
         end else begin
            chk(arm_req == 1'b0, "R8", "gap cycle", 64'(arm_req), 64'd0);
            step();
            chk(arm_req == 1'b1, "R8", "re-arm at c+2", 64'(arm_req), 64'd1);
         end
      end
      trig = 1'b1;
      step();
      trig = 1'b0;
      cap_done = 1'b1;
      chk(ts_we == 1'b0, "R9", "trigger after done", 64'(ts_we), 64'd0);
      step();
      cap_done = 1'b0;
      step();
      chk(all_done == 1'b1 && arm_req == 1'b0, "R9", "done held",
          64'({all_done, arm_req}), 64'h2);
   endtask

   initial begin
      repeat (3) step();
      chk(!arm_req && !all_done && !ts_we && base_addr == '0, "R1", "reset state",
          64'({arm_req, all_done, ts_we}), 64'd0);
      rst_n = 1'b1;
      step();
      trig = 1'b1;
      step();
      trig = 1'b0;
      step();
      chk(!arm_req && !all_done && !ts_we && base_addr == '0, "R1", "idle ignores trigger",
          64'({arm_req, all_done, ts_we}), 64'd0);

      run_seq(3, 2, 1'b1);
      for (int c = 0; c <= 6; c++) begin
         for (int l = 1; l <= 3; l++) begin
            run_seq(c, l, 1'b0);
         end
      end
      run_seq(15, 15, 1'b0);

      // restart in the middle of a sequence
      do_start(4, 1);
      trig = 1'b1;
      step();
      trig = 1'b0;
      cap_done = 1'b1;
      step();
      cap_done = 1'b0;
      step();
      chk(base_addr == ADDR_W'(1 << UNIT_LOG2), "R3", "second segment base",
          64'(base_addr), 64'(1 << UNIT_LOG2));
      do_start(2, 3);
      trig = 1'b1;
      step();
      trig = 1'b0;
      chk(ts_addr == '0, "R2", "index restarted", 64'(ts_addr), 64'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule